// File: doc/BRIEF.md
# Configuration Register I2C Target

This block is an I2C target that runs on a fast system clock. It synchronises SCL and SDA and finds START, repeated START and STOP conditions. It answers a 7-bit address. The upper bits of that address are fixed by a parameter, and the two low bits come from strap pins. The first byte written after the address is a command byte. The block accepts the command or refuses it. It stages up to two data bytes for a pair of 6-bit stored configuration registers, and it writes them only when the STOP arrives.

On a read, the block returns data chosen by the last accepted command. It can return one of the stored registers, the five input pins, or the command byte itself. The accepted command byte is also driven out, so an output selector next to the block can follow it. After every committed write the block is busy for a programmable number of clock cycles, and it refuses its own address during that time.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ADDR_HI, addr_pins_i}, sent MSB first. The eighth bit selects the direction: 1 means read and 0 means write. Any other address is left unacknowledged.
- R2: As the first byte after a write address, the block acknowledges only 0x00, 0x01, 0xFF and any value of the form 1111_1xxx. It leaves every other value unacknowledged. cmd_o shows the last accepted command and keeps its value when a command is refused.
- R3: After command 0x00 or 0x01, the first data byte is staged for the register that the command names, and a second data byte is staged for the other register. The staged bytes are stored on STOP, and only bits [5:0] are kept.
- R4: A third data byte after a register command is left unacknowledged. When that happens, no register changes at the following STOP.
- R5: While wp_i is 1, the address and the command are acknowledged, but every data byte is left unacknowledged and no register changes.
- R6: After command 0xFF or a 1111_1xxx command, every data byte is left unacknowledged and no register changes.
- R7: After a register command, each read byte is {2'b00, register}. The first byte comes from the register named by the command, and each byte sent moves the pointer to the other register.
- R8: After command 0xFF, a read returns {3'b000, pins_i}. After a 1111_1xxx command, a read returns the command byte.
- R9: For BUSY_CYCLES clock cycles after a committed write, the block does not acknowledge its own address.
- R10: After reset, both registers read zero, cmd_o is 0x00 and SDA is released.
- R11: When the controller does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R12: The block acknowledges by pulling SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth. The SDA drive changes only while SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_pins_i | input | 2 | Low address bits from strap pins |
| wp_i | input | 1 | Write protect, 1 blocks register writes |
| pins_i | input | 5 | Input pin values returned by command 0xFF |
| reg0_o | output | 6 | Stored register 0 |
| reg1_o | output | 6 | Stored register 1 |
| cmd_o | output | 8 | Last accepted command byte |

## Verification
Write transactions are driven with zero to three data bytes, under each command class and with write protect on and off. This separates acknowledged-and-staged bytes from refused bytes, and an overflow abort from a normal commit. Reads are issued after each of the three command kinds. They show whether the pointer alternates and whether pin data and command data are chosen correctly. The tests also send foreign and mismatched-strap addresses, address the block twice around the busy window, and clock extra bits after a controller NACK. These show the address comparison, the busy lockout and the release of SDA.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } rx_ph_e;

    localparam logic [7:0] CMD_PINS = 8'hFF;

    function automatic logic cmd_is_reg(input logic [7:0] b);
        return b[7:1] == 7'd0;
    endfunction

    function automatic logic cmd_accept(input logic [7:0] b);
        return cmd_is_reg(b) || (b[7:3] == 5'b11111);
    endfunction

endpackage

// File: rtl/cfg_i2c_sampler.sv
module cfg_i2c_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int PW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] scl;
        logic [PW-1:0] sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d     = smp_q;
        smp_d.scl = {smp_q.scl[PW-2:0], scl_i};
        smp_d.sda = {smp_q.sda[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = smp_q.scl[PW-2];
    assign scl_old = smp_q.scl[PW-1];
    assign sda_now = smp_q.sda[PW-2];
    assign sda_old = smp_q.sda[PW-1];

    assign scl_o      = scl_now;
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/cfg_i2c_busy_timer.sv
module cfg_i2c_busy_timer #(
    parameter int CYCLES = 360000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = W'(CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R9: a commit always opens the lockout window
    a_r9_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int               ADDR_PIN_W  = 2,
    parameter logic [6-ADDR_PIN_W:0] ADDR_HI = 5'b10011,
    parameter int               REG_W       = 6,
    parameter int               PIN_W       = 5,
    parameter int               SYNC_STAGES = 2,
    parameter int               BUSY_CYCLES = 360000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [ADDR_PIN_W-1:0] addr_pins_i,
    input  logic                  wp_i,
    input  logic [PIN_W-1:0]      pins_i,
    output logic [REG_W-1:0]      reg0_o,
    output logic [REG_W-1:0]      reg1_o,
    output logic [7:0]            cmd_o
);
    localparam int MAX_DATA = 2;

    typedef struct packed {
        bus_st_e          st;
        rx_ph_e           ph;
        logic [3:0]       bcnt;
        logic [7:0]       sh;
        logic [7:0]       cmd;
        logic             ptr;
        logic [1:0]       ndata;
        logic [REG_W-1:0] stg0;
        logic [REG_W-1:0] stg1;
        logic [1:0]       stg_v;
        logic             poison;
        logic             rd;
        logic             mack;
        logic             oe;
        logic [REG_W-1:0] r0;
        logic [REG_W-1:0] r1;
    } ctx_t;

    ctx_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic busy, commit, ack;
    logic [6:0] dev_addr;
    logic [7:0] tx_byte;

    cfg_i2c_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    cfg_i2c_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (commit),
        .busy_o (busy)
    );

    assign dev_addr = {ADDR_HI, addr_pins_i};

    always_comb begin
        if (cmd_is_reg(q.cmd))      tx_byte = 8'(q.ptr ? q.r1 : q.r0);
        else if (q.cmd == CMD_PINS) tx_byte = 8'(pins_i);
        else                        tx_byte = q.cmd;
    end

    always_comb begin
        n      = q;
        commit = 1'b0;
        ack    = 1'b0;
        if (start) begin
            n.st   = ST_RX;
            n.ph   = PH_ADDR;
            n.bcnt = '0;
            n.oe   = 1'b0;
        end else if (stop) begin
            if (q.stg_v != 2'b00 && !q.poison) begin
                if (q.stg_v[0]) n.r0 = q.stg0;
                if (q.stg_v[1]) n.r1 = q.stg1;
                commit = 1'b1;
            end
            n.stg_v  = 2'b00;
            n.poison = 1'b0;
            n.ndata  = '0;
            n.oe     = 1'b0;
            n.st     = ST_IDLE;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bcnt < 4'd8) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bcnt = q.bcnt + 4'd1;
                    end else if (scl_fall && q.bcnt == 4'd8) begin
                        case (q.ph)
                            PH_ADDR: if (q.sh[7:1] == dev_addr && !busy) begin
                                ack  = 1'b1;
                                n.rd = q.sh[0];
                                n.ph = PH_CMD;
                            end
                            PH_CMD: if (cmd_accept(q.sh)) begin
                                ack     = 1'b1;
                                n.cmd   = q.sh;
                                n.ndata = '0;
                                if (cmd_is_reg(q.sh)) n.ptr = q.sh[0];
                                n.ph    = PH_DATA;
                            end
                            PH_DATA: if (cmd_is_reg(q.cmd) && !wp_i) begin
                                if (q.ndata < 2'(MAX_DATA)) begin
                                    ack     = 1'b1;
                                    n.ndata = q.ndata + 2'd1;
                                    n.ptr   = ~q.ptr;
                                    if (q.ptr) begin
                                        n.stg1     = q.sh[REG_W-1:0];
                                        n.stg_v[1] = 1'b1;
                                    end else begin
                                        n.stg0     = q.sh[REG_W-1:0];
                                        n.stg_v[0] = 1'b1;
                                    end
                                end else begin
                                    n.poison = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                        n.bcnt = '0;
                        n.st   = ack ? ST_ACK : ST_SKIP;
                        n.oe   = ack;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    if (q.ph == PH_CMD && q.rd) begin
                        n.sh   = tx_byte;
                        n.oe   = ~tx_byte[7];
                        n.bcnt = 4'd1;
                        n.st   = ST_TX;
                        if (cmd_is_reg(q.cmd)) n.ptr = ~q.ptr;
                    end else begin
                        n.oe = 1'b0;
                        n.st = ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (q.bcnt < 4'd8) begin
                        n.sh   = {q.sh[6:0], 1'b0};
                        n.oe   = ~q.sh[6];
                        n.bcnt = q.bcnt + 4'd1;
                    end else begin
                        n.oe   = 1'b0;
                        n.bcnt = '0;
                        n.st   = ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) n.mack = ~sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            n.sh   = tx_byte;
                            n.oe   = ~tx_byte[7];
                            n.bcnt = 4'd1;
                            n.st   = ST_TX;
                            if (cmd_is_reg(q.cmd)) n.ptr = ~q.ptr;
                        end else begin
                            n.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe_o = q.oe;
    assign reg0_o   = q.r0;
    assign reg1_o   = q.r1;
    assign cmd_o    = q.cmd;

    // R12: the SDA drive moves only while SCL is low, unless a START or STOP released it
    a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.oe) && !$past(start) && !$past(stop)) |-> !scl_s);

    // R9: the own address is never acknowledged inside the lockout window
    a_r9_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.st == ST_RX && q.ph == PH_ADDR && !start && !stop) |=> q.st != ST_ACK);

    // R5: write protect refuses every data byte
    a_r5_wp_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_i && q.st == ST_RX && q.ph == PH_DATA && !start && !stop) |=> q.st != ST_ACK);

    // R4: an overflowed transaction leaves both registers alone
    a_r4_overflow_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && q.poison) |=> (q.r0 == $past(q.r0) && q.r1 == $past(q.r1)));

    // R2: only an accepted command value ever reaches cmd_o
    a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cmd) |-> (q.cmd[7:1] == 7'd0 || q.cmd[7:3] == 5'b11111));

endmodule

// File: tb/cfg_i2c_target_tb_top.sv
module cfg_i2c_target_tb_top;
    localparam int H     = 20;
    localparam int BUSY  = 1000;
    localparam int LIMIT = 150000;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic       wp;
        logic [1:0] n;
        logic [7:0] cmd;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
        logic [3:0] acks;   // {cmd, d0, d1, d2}
        logic [7:0] ecmd;
        logic [5:0] er0;
        logic [5:0] er1;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd1, 8'h00, 8'h2A, 8'h00, 8'h00, 4'b1100, 8'h00, 6'h2A, 6'h00},
        '{1'b0, 2'd1, 8'h01, 8'hFF, 8'h00, 8'h00, 4'b1100, 8'h01, 6'h2A, 6'h3F},
        '{1'b0, 2'd2, 8'h00, 8'h15, 8'h0C, 8'h00, 4'b1110, 8'h00, 6'h15, 6'h0C},
        '{1'b0, 2'd2, 8'h01, 8'h33, 8'h01, 8'h00, 4'b1110, 8'h01, 6'h01, 6'h33},
        '{1'b1, 2'd1, 8'h00, 8'h3F, 8'h00, 8'h00, 4'b1000, 8'h00, 6'h01, 6'h33},
        '{1'b0, 2'd3, 8'h00, 8'h10, 8'h20, 8'h30, 4'b1110, 8'h00, 6'h01, 6'h33},
        '{1'b0, 2'd0, 8'h02, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 6'h01, 6'h33},
        '{1'b0, 2'd1, 8'hF9, 8'h11, 8'h00, 8'h00, 4'b1000, 8'hF9, 6'h01, 6'h33},
        '{1'b0, 2'd1, 8'hFF, 8'h05, 8'h00, 8'h00, 4'b1000, 8'hFF, 6'h01, 6'h33},
        '{1'b0, 2'd1, 8'hC4, 8'h07, 8'h00, 8'h00, 4'b0000, 8'hFF, 6'h01, 6'h33}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, scl_m, sda_m, wp;
    logic [1:0] apins;
    logic [4:0] pins;
    logic       sda_oe, sda_bus;
    logic [5:0] r0, r1;
    logic [7:0] cmd;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    assign sda_bus = sda_m & ~sda_oe;

    cfg_i2c_target #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .addr_pins_i (apins),
        .wp_i        (wp),
        .pins_i      (pins),
        .reg0_o      (r0),
        .reg1_o      (r1),
        .cmd_o       (cmd)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl_m = 1'b0; tick(H);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        b = sda_bus;  tick(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        acked = (s == 1'b0);
    endtask

    task automatic rd(input bit give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_in(s);
            b[i] = s;
        end
        bit_out(give_ack ? 1'b0 : 1'b1);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
        apins = 2'b10; pins = 5'b10110;
        tick(5);
        // R10 reset state
        chk(r0 == 6'h00, "R10 reg0 reset", 8'(r0), 8'h00);
        chk(r1 == 6'h00, "R10 reg1 reset", 8'(r1), 8'h00);
        chk(cmd == 8'h00, "R10 cmd reset", cmd, 8'h00);
        chk(sda_oe == 1'b0, "R10 sda released", 8'(sda_oe), 8'h00);
        rst_n = 1'b1;
        tick(5);

        // write vectors: R2 R3 R4 R5 R6 (R12 ack timing seen through the sampled ack bit)
        for (int v = 0; v < NVEC; v++) begin
            automatic vec_t  t = VECS[v];
            automatic logic [7:0] db [3] = '{t.d0, t.d1, t.d2};
            wp = t.wp;
            bus_start();
            wr(8'h9C, a);
            chk(a == 1'b1, "R1 address ack", 8'(a), 8'h01);
            wr(t.cmd, a);
            chk(a == t.acks[3], "R2 command ack", 8'(a), 8'(t.acks[3]));
            if (a) begin
                for (int k = 0; k < int'(t.n); k++) begin
                    wr(db[k], a);
                    chk(a == t.acks[2-k], "R3/R4/R5/R6 data ack", 8'(a), 8'(t.acks[2-k]));
                    if (!a) break;
                end
            end
            bus_stop();
            wp = 1'b0;
            tick(BUSY + 200);
            chk(r0 == t.er0, "R3/R4/R5/R6 reg0", 8'(r0), 8'(t.er0));
            chk(r1 == t.er1, "R3/R4/R5/R6 reg1", 8'(r1), 8'(t.er1));
            chk(cmd == t.ecmd, "R2 cmd_o", cmd, t.ecmd);
        end

        // R7 register read with pointer alternation, then R11 release after NACK
        bus_start();
        wr(8'h9C, a);
        wr(8'h00, a);
        bus_start();
        wr(8'h9D, a);
        chk(a == 1'b1, "R1 read address ack", 8'(a), 8'h01);
        rd(1'b1, b);
        chk(b == 8'h01, "R7 first byte reg0", b, 8'h01);
        rd(1'b0, b);
        chk(b == 8'h33, "R7 second byte reg1", b, 8'h33);
        tick(8);
        chk(sda_oe == 1'b0, "R11 released after nack", 8'(sda_oe), 8'h00);
        rd(1'b0, b);
        chk(b == 8'hFF, "R11 no drive on extra bits", b, 8'hFF);
        bus_stop();
        tick(100);

        // R7 start from register 1
        bus_start();
        wr(8'h9C, a);
        wr(8'h01, a);
        bus_start();
        wr(8'h9D, a);
        rd(1'b0, b);
        chk(b == 8'h33, "R7 read from reg1", b, 8'h33);
        bus_stop();
        tick(100);

        // R8 pin read, twice with different pin values
        bus_start();
        wr(8'h9C, a);
        wr(8'hFF, a);
        bus_start();
        wr(8'h9D, a);
        rd(1'b0, b);
        chk(b == 8'h16, "R8 pins read", b, 8'h16);
        bus_stop();
        pins = 5'b01001;
        tick(50);
        bus_start();
        wr(8'h9D, a);
        rd(1'b0, b);
        chk(b == 8'h09, "R8 pins read again", b, 8'h09);
        bus_stop();
        tick(100);

        // R8 selector command reads back
        bus_start();
        wr(8'h9C, a);
        wr(8'hF9, a);
        bus_stop();
        tick(50);
        bus_start();
        wr(8'h9D, a);
        rd(1'b0, b);
        chk(b == 8'hF9, "R8 selector read", b, 8'hF9);
        bus_stop();
        tick(100);

        // R1 foreign address and strap pin dependence
        bus_start();
        wr(8'h9E, a);
        chk(a == 1'b0, "R1 foreign address nack", 8'(a), 8'h00);
        bus_stop();
        apins = 2'b01;
        tick(50);
        bus_start();
        wr(8'h9C, a);
        chk(a == 1'b0, "R1 old strap nack", 8'(a), 8'h00);
        bus_stop();
        bus_start();
        wr(8'h9A, a);
        chk(a == 1'b1, "R1 new strap ack", 8'(a), 8'h01);
        bus_stop();
        apins = 2'b10;
        tick(100);

        // R9 busy lockout after a committed write
        bus_start();
        wr(8'h9C, a);
        wr(8'h00, a);
        wr(8'h3C, a);
        bus_stop();
        tick(10);
        bus_start();
        wr(8'h9C, a);
        chk(a == 1'b0, "R9 nack while busy", 8'(a), 8'h00);
        bus_stop();
        tick(BUSY + 200);
        bus_start();
        wr(8'h9C, a);
        chk(a == 1'b1, "R9 ack after busy", 8'(a), 8'h01);
        bus_stop();
        tick(50);
        chk(r0 == 6'h3C, "R3 reg0 after lockout write", 8'(r0), 8'h3C);
        chk(r1 == 6'h33, "R3 reg1 untouched", 8'(r1), 8'h33);

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule